// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block turns a 32.768 kHz tick enable into a periodic event. The rate is set by a 4-bit rate code, and the period is a power of two of that time base. A free-running 15-bit tick counter sets the phase of every event. An event fires when the counter reaches an exact multiple of the selected period. It does not fire a fixed time after the block is enabled or reconfigured.

Each event raises three registered single-cycle pulses. The flag pulse fires on every event. The interrupt request pulse fires only when the periodic interrupt enable is set. The square-wave pulse fires only when the square-wave enable is set. The square-wave output is a pulse, not a 50% duty waveform. Code 0 stops event generation. Clearing both enables also stops it. The tick counter keeps running in either case, so the alignment to period multiples is never lost.

Top module: `rate_pulse_gen`

## Requirements
- R1: Synchronous active-high `rst` clears the tick counter and drives all three outputs low. After reset, the first event at period P comes on the P-th tick.
- R2: With `rate_sel` equal to 0, no event fires, whatever the enables are.
- R3: Codes 1 and 2 act as codes 8 and 9. Their periods are 128 and 256 ticks.
- R4: Codes 3 to 15 give a period of 2^(code-1) ticks. Code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R5: An event fires on the tick that brings the counter to a nonzero multiple of the period, or wraps it to zero. The time since the last enable or code change does not matter.
- R6: When `pint_en` and `sqw_en` are both low, no event fires. The counter keeps counting ticks.
- R7: `flag_set` pulses on every event. `irq_req` pulses with it only when `pint_en` is high.
- R8: `sqw_pulse` pulses for one cycle with an event only when `sqw_en` is high.
- R9: All outputs are registered. A pulse is high in the clock cycle right after the tick edge that caused it, and for that one cycle only.
- R10: Changes to the code or to the enables are judged at the next tick. A change made between ticks never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle strobe at 32.768 kHz |
| rate_sel | input | 4 | Rate code (0 stops events) |
| pint_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| flag_set | output | 1 | Periodic flag set pulse |
| irq_req | output | 1 | Interrupt request pulse |
| sqw_pulse | output | 1 | Square-wave pulse |

## Verification
Every output is due exactly one clock after the rising edge at which `tick_en` is high. The bench holds each tick strobe for one full cycle, from one falling edge to the next. It reads the outputs at the falling edge that ends the strobe, and reads them again one cycle later to confirm that the pulse has cleared. Configuration changes are applied on falling edges between ticks, with no tick present, so their effect shows only at the next tick sample.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    localparam int CNT_W       = 15;
    localparam int CODE_W      = 4;
    localparam int ALIAS_TOP   = 2;
    localparam int ALIAS_SHIFT = 7;

    typedef struct packed {
        logic flag;
        logic irq;
        logic sqw;
    } evt_t;

    // Map the low codes onto their slower equivalents.
    function automatic logic [CODE_W-1:0] eff_code(input logic [CODE_W-1:0] c);
        if (c != '0 && c <= CODE_W'(ALIAS_TOP))
            return c + CODE_W'(ALIAS_SHIFT);
        return c;
    endfunction

endpackage

// File: rtl/rpg_rate_decode.sv
module rpg_rate_decode #(
    parameter int CNT_W  = rpg_pkg::CNT_W,
    parameter int CODE_W = rpg_pkg::CODE_W
) (
    input  logic [CODE_W-1:0] code,
    output logic              active,
    output logic [CNT_W-1:0]  low_mask
);
    logic [CODE_W-1:0] eff;

    assign eff    = rpg_pkg::eff_code(code);
    assign active = (eff != '0);

    // Bit b takes part in the alignment test when b < eff-1.
    for (genvar b = 0; b < CNT_W; b++) begin : g_mask
        assign low_mask[b] = active && (b < (int'(eff) - 1));
    end
endmodule

// File: rtl/rpg_tick_counter.sv
module rpg_tick_counter #(
    parameter int CNT_W = rpg_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    output logic [CNT_W-1:0] next_val
);
    logic [CNT_W-1:0] cnt_q;

    assign next_val = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick_en)
            cnt_q <= next_val;
    end
endmodule

// File: rtl/rpg_event_gate.sv
module rpg_event_gate #(
    parameter int CNT_W = rpg_pkg::CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_en,
    input  logic               active,
    input  logic [CNT_W-1:0]   low_mask,
    input  logic [CNT_W-1:0]   next_val,
    input  logic               pint_en,
    input  logic               sqw_en,
    output rpg_pkg::evt_t      evt_q
);
    logic run;
    logic on_boundary;
    logic hit;

    assign run         = active && (pint_en || sqw_en);
    assign on_boundary = ((next_val & low_mask) == '0);
    assign hit         = tick_en && run && on_boundary;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
        end else begin
            evt_q.flag <= hit;
            evt_q.irq  <= hit && pint_en;
            evt_q.sqw  <= hit && sqw_en;
        end
    end
endmodule

// File: rtl/rate_pulse_gen.sv
module rate_pulse_gen #(
    parameter int CNT_W  = rpg_pkg::CNT_W,
    parameter int CODE_W = rpg_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [CODE_W-1:0] rate_sel,
    input  logic              pint_en,
    input  logic              sqw_en,
    output logic              flag_set,
    output logic              irq_req,
    output logic              sqw_pulse
);
    logic              active;
    logic [CNT_W-1:0]  low_mask;
    logic [CNT_W-1:0]  next_val;
    rpg_pkg::evt_t     evt_q;

    rpg_rate_decode #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_dec (
        .code     (rate_sel),
        .active   (active),
        .low_mask (low_mask)
    );

    rpg_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .next_val (next_val)
    );

    rpg_event_gate #(.CNT_W(CNT_W)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .active   (active),
        .low_mask (low_mask),
        .next_val (next_val),
        .pint_en  (pint_en),
        .sqw_en   (sqw_en),
        .evt_q    (evt_q)
    );

    assign flag_set  = evt_q.flag;
    assign irq_req   = evt_q.irq;
    assign sqw_pulse = evt_q.sqw;
endmodule

// File: rtl/rpg_chk.sv
module rpg_chk #(
    parameter int CODE_W = rpg_pkg::CODE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic [CODE_W-1:0] rate_sel,
    input logic              pint_en,
    input logic              sqw_en,
    input logic              flag_set,
    input logic              irq_req,
    input logic              sqw_pulse
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!flag_set && !irq_req && !sqw_pulse));

    // R2
    code_zero_chk: assert property (@(posedge clk) disable iff (rst)
        flag_set |-> ($past(rate_sel) != '0));

    // R6
    stopped_chk: assert property (@(posedge clk) disable iff (rst)
        flag_set |-> ($past(pint_en) || $past(sqw_en)));

    // R7
    irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (flag_set && $past(pint_en)));

    // R8
    sqw_gated_chk: assert property (@(posedge clk) disable iff (rst)
        sqw_pulse |-> (flag_set && $past(sqw_en)));

    // R9
    one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        flag_set |=> !flag_set);

    // R10
    tick_only_chk: assert property (@(posedge clk) disable iff (rst)
        flag_set |-> $past(tick_en));
endmodule

bind rate_pulse_gen rpg_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .rate_sel  (rate_sel),
    .pint_en   (pint_en),
    .sqw_en    (sqw_en),
    .flag_set  (flag_set),
    .irq_req   (irq_req),
    .sqw_pulse (sqw_pulse)
);

// File: tb/rate_pulse_gen_bench.sv
module rate_pulse_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       pint_en = 1'b0;
    logic       sqw_en = 1'b0;
    logic       flag_set;
    logic       irq_req;
    logic       sqw_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    rate_pulse_gen u_rate_pulse_gen (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .rate_sel  (rate_sel),
        .pint_en   (pint_en),
        .sqw_en    (sqw_en),
        .flag_set  (flag_set),
        .irq_req   (irq_req),
        .sqw_pulse (sqw_pulse)
    );

    typedef struct packed {
        logic [3:0]  code;
        logic        pint;
        logic        sqw;
        logic [15:0] nticks;
        logic [7:0]  exp_flag;
        logic [7:0]  exp_irq;
        logic [7:0]  exp_sqw;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  1'b1, 1'b1, 16'd64,    8'd0, 8'd0, 8'd0},  // R2
        '{4'd3,  1'b1, 1'b0, 16'd20,    8'd5, 8'd5, 8'd0},  // R4 R7
        '{4'd4,  1'b0, 1'b1, 16'd20,    8'd2, 8'd0, 8'd2},  // R4 R8
        '{4'd5,  1'b1, 1'b1, 16'd50,    8'd3, 8'd3, 8'd3},  // R4 R7 R8
        '{4'd1,  1'b1, 1'b0, 16'd300,   8'd2, 8'd2, 8'd0},  // R3
        '{4'd2,  1'b0, 1'b1, 16'd600,   8'd2, 8'd0, 8'd2},  // R3
        '{4'd8,  1'b1, 1'b0, 16'd300,   8'd2, 8'd2, 8'd0},  // R3 reference
        '{4'd6,  1'b0, 1'b0, 16'd100,   8'd0, 8'd0, 8'd0},  // R6
        '{4'd15, 1'b1, 1'b1, 16'd16400, 8'd1, 8'd1, 8'd1},  // R4 top code
        '{4'd9,  1'b1, 1'b1, 16'd256,   8'd1, 8'd1, 8'd1}   // R3 reference
    };

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tick_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One tick strobe; outputs are read at the falling edge that ends it.
    task automatic tick(output bit f, output bit i, output bit s);
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        f = flag_set;
        i = irq_req;
        s = sqw_pulse;
    endtask

    task automatic run_ticks(input int n, output int nf, output int ni, output int ns);
        bit f, i, s;
        nf = 0; ni = 0; ns = 0;
        for (int k = 0; k < n; k++) begin
            tick(f, i, s);
            nf += int'(f);
            ni += int'(i);
            ns += int'(s);
        end
    endtask

    task automatic set_cfg(input logic [3:0] c, input logic p, input logic q);
        @(negedge clk);
        rate_sel = c;
        pint_en  = p;
        sqw_en   = q;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int nf, ni, ns;
        bit f, i, s;

        // R1: outputs low straight out of reset
        do_reset();
        check(!flag_set && !irq_req && !sqw_pulse, "R1 reset outputs",
              int'({flag_set, irq_req, sqw_pulse}), 0);

        // Table walk (R2 R3 R4 R6 R7 R8)
        for (int v = 0; v < NVEC; v++) begin
            set_cfg(VECS[v].code, VECS[v].pint, VECS[v].sqw);
            do_reset();
            run_ticks(int'(VECS[v].nticks), nf, ni, ns);
            check(nf == int'(VECS[v].exp_flag), $sformatf("R4 R3 R2 R6 table %0d flag", v), nf, int'(VECS[v].exp_flag));
            check(ni == int'(VECS[v].exp_irq),  $sformatf("R7 table %0d irq", v), ni, int'(VECS[v].exp_irq));
            check(ns == int'(VECS[v].exp_sqw),  $sformatf("R8 table %0d sqw", v), ns, int'(VECS[v].exp_sqw));
        end

        // R1: reset mid-count restarts the phase
        set_cfg(4'd3, 1'b1, 1'b0);
        do_reset();
        run_ticks(3, nf, ni, ns);
        do_reset();
        run_ticks(3, nf, ni, ns);
        check(nf == 0, "R1 counter cleared, ticks 1-3", nf, 0);
        tick(f, i, s);
        check(f == 1'b1, "R1 event on 4th tick after reset", int'(f), 1);

        // R9: pulse lasts exactly one cycle
        @(negedge clk);
        check(!flag_set && !irq_req, "R9 pulse cleared next cycle",
              int'({flag_set, irq_req}), 0);

        // R5: events land on multiples, not a fixed delay after enabling
        set_cfg(4'd0, 1'b1, 1'b0);
        do_reset();
        run_ticks(10, nf, ni, ns);
        set_cfg(4'd3, 1'b1, 1'b0);
        tick(f, i, s);
        check(f == 1'b0, "R5 no event at count 11", int'(f), 0);
        tick(f, i, s);
        check(f == 1'b1, "R5 event at count 12", int'(f), 1);
        run_ticks(4, nf, ni, ns);
        check(nf == 1, "R5 one event up to count 16", nf, 1);

        // R10: rate change judged at the next tick
        set_cfg(4'd3, 1'b1, 1'b0);
        do_reset();
        run_ticks(5, nf, ni, ns);
        set_cfg(4'd5, 1'b1, 1'b0);
        run_ticks(3, nf, ni, ns);
        check(nf == 0, "R10 new period 16, none at 8", nf, 0);
        run_ticks(8, nf, ni, ns);
        check(nf == 1, "R10 event at count 16", nf, 1);

        // R6/R10: enables dropped between ticks, counter keeps running
        set_cfg(4'd5, 1'b0, 1'b0);
        run_ticks(16, nf, ni, ns);
        check(nf == 0, "R6 stopped at count 32", nf, 0);
        set_cfg(4'd5, 1'b0, 1'b1);
        run_ticks(16, nf, ni, ns);
        check(nf == 1 && ns == 1 && ni == 0, "R6 phase kept, event at 48",
              nf * 100 + ns * 10 + ni, 110);

        // R10: config changes with no tick give no pulse
        nf = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            rate_sel = 4'(k + 3);
            pint_en  = k[0];
            sqw_en   = k[1];
            nf += int'(flag_set) + int'(irq_req) + int'(sqw_pulse);
        end
        @(negedge clk);
        nf += int'(flag_set) + int'(irq_req) + int'(sqw_pulse);
        check(nf == 0, "R10 no glitch without tick", nf, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule